// File: doc/BRIEF.md
# Reloading Timer/Event Counter with Capture Mode

The block is an up-counter that restarts from a software-loaded start value every time it passes its top count. It has three counting sources. In timer mode it advances on system-clock ticks divided by a power-of-two prescaler. In event mode it advances on one chosen edge of an external pin. In capture mode it advances on prescaled ticks, but only while the pin sits at a chosen level, so the count measures a pulse width. A synchronizer brings the external pin into the clock domain before it is used. The count therefore lags the pin by the synchronizer depth, and a measurement can be off by one tick.

When the counter is at all ones and takes one more step, three things happen on the same clock edge. The counter reloads the start value, a one-cycle overflow pulse is emitted, and a sticky interrupt flag is set. The interrupt request output is that flag gated by an enable bit. Software reaches the block through a plain single-cycle register port. Writes and reads are strobes that complete in the cycle they are asserted; there is no handshake and no back-pressure. Read data is combinational from the address.

A clock edge on which the counter is read, or on which the start value is written, does not advance the count. This keeps the count from changing under an access.

Top module: `reload_timer`

## Requirements
- R1: After reset, the counter, start value and control register read 0, and `ovf_pulse` and `irq` are 0.
- R2: Register map on `reg_addr`: 0 is the start value (read/write), 1 is control, 2 is the counter (read only), and 3 is status (bit 0 is the flag; any write clears it). Control bits: bit 0 enable; bits 2:1 mode (00 timer, 01 event, 10 capture, 11 hold with no counting); bit 3 polarity; bits 6:4 prescale select s; bit 7 interrupt enable.
- R3: In timer mode, with prescale select s, the counter advances once per 2^s clock edges. The first advance falls on the 2^s-th edge after the enabling write.
- R4: In event mode, the counter advances once per synchronized rising edge of `ext_in` (polarity 0) or falling edge (polarity 1). The prescaler has no effect in this mode.
- R5: In capture mode, the counter advances on prescaled ticks only while the synchronized `ext_in` is high (polarity 0) or low (polarity 1).
- R6: `ext_in` passes through a two-flop synchronizer. A level held for H cycles gives exactly H counts in capture mode with s = 0.
- R7: The step after all ones loads the start value, and `ovf_pulse` is high for the one cycle after that edge.
- R8: An edge with a counter read (address 2) or a start-value write does not advance the counter. A start-value write does not change the running count.
- R9: A control write that sets enable while enable is 0 loads the start value and restarts the prescaler. With enable at 0, the counter holds its value.
- R10: Overflow sets the status flag, and the flag stays set until a status write; set wins over clear. `irq` is the flag ANDed with interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used to inhibit counting) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| ext_in | input | 1 | Asynchronous external event / gate input |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The assertions assume that software does not read the counter and write a register in the same cycle. The counter-hold property relies on a bare read, and the stimulus never overlaps the two strobes. They also assume `ext_in` changes are slow enough for the synchronizer. The bench holds each external level for at least two cycles and drives it only on the falling clock edge. The reload property depends on no start-value write landing on an overflow edge. That write inhibits the step, so the two cannot coincide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_EVENT   = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_HOLD    = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] ADDR_PRELOAD = 2'd0;
  localparam logic [1:0] ADDR_CTRL    = 2'd1;
  localparam logic [1:0] ADDR_COUNT   = 2'd2;
  localparam logic [1:0] ADDR_STATUS  = 2'd3;
endpackage

// File: rtl/tmr_in_sync.sv
module tmr_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  // STAGES synchronizing flops plus one history flop for edge detection
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], pin};
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   one_hot;
  logic [DIV_W-1:0] mask;

  always_comb begin
    one_hot = {{DIV_W{1'b0}}, 1'b1} << sel;
    mask    = DIV_W'(one_hot - 1'b1);
  end

  assign tick = run & ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (clear) div_q <= '0;
    else if (run)   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] start_val,
  output logic [W-1:0] cnt,
  output logic         full,
  output logic         wrap
);
  assign full = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (load) begin
        cnt <= start_val;
      end else if (step) begin
        if (full) begin
          cnt  <= start_val;
          wrap <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_SEL_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             ext_in,
  output logic             ovf_pulse,
  output logic             irq
);
  localparam int EN_BIT   = 0;
  localparam int MODE_LSB = 1;
  localparam int POL_BIT  = 3;
  localparam int PSEL_LSB = 4;
  localparam int IE_BIT   = PSEL_LSB + PSC_SEL_W;
  localparam int CTRL_W   = IE_BIT + 1;

  logic                 en_q, pol_q, ie_q, flag_q;
  tmr_mode_e            mode_q;
  logic [PSC_SEL_W-1:0] psel_q;
  logic [CNT_W-1:0]     preload_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 cnt_full;

  logic wr_pre, wr_ctl, wr_clr, rd_cnt, start, inhibit;
  logic pin_lvl, pin_rise, pin_fall, psc_tick, psc_run, src, step;

  assign wr_pre  = reg_wr && reg_addr == ADDR_PRELOAD;
  assign wr_ctl  = reg_wr && reg_addr == ADDR_CTRL;
  assign wr_clr  = reg_wr && reg_addr == ADDR_STATUS;
  assign rd_cnt  = reg_rd && reg_addr == ADDR_COUNT;
  assign start   = wr_ctl && reg_wdata[EN_BIT] && !en_q;
  assign inhibit = rd_cnt || wr_pre;

  tmr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_in),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign psc_run = en_q && (mode_q == MODE_TIMER || mode_q == MODE_CAPTURE);

  tmr_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .clear(start), .run(psc_run),
    .sel(psel_q), .tick(psc_tick)
  );

  always_comb begin
    unique case (mode_q)
      MODE_TIMER:   src = psc_tick;
      MODE_EVENT:   src = pol_q ? pin_fall : pin_rise;
      MODE_CAPTURE: src = psc_tick && (pin_lvl ^ pol_q);
      default:      src = 1'b0;
    endcase
  end

  assign step = en_q && !inhibit && !start && src;

  tmr_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step),
    .start_val(preload_q), .cnt(cnt_q), .full(cnt_full), .wrap(ovf_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '0;
      en_q      <= 1'b0;
      mode_q    <= MODE_TIMER;
      pol_q     <= 1'b0;
      psel_q    <= '0;
      ie_q      <= 1'b0;
    end else begin
      if (wr_pre) preload_q <= reg_wdata;
      if (wr_ctl) begin
        en_q   <= reg_wdata[EN_BIT];
        mode_q <= tmr_mode_e'(reg_wdata[MODE_LSB +: 2]);
        pol_q  <= reg_wdata[POL_BIT];
        psel_q <= reg_wdata[PSEL_LSB +: PSC_SEL_W];
        ie_q   <= reg_wdata[IE_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (step && cnt_full)   flag_q <= 1'b1;
    else if (wr_clr)             flag_q <= 1'b0;
  end

  assign irq = flag_q && ie_q;

  always_comb begin
    unique case (reg_addr)
      ADDR_PRELOAD: reg_rdata = preload_q;
      ADDR_CTRL:    reg_rdata = CNT_W'({ie_q, psel_q, pol_q, mode_q, en_q});
      ADDR_COUNT:   reg_rdata = cnt_q;
      default:      reg_rdata = CNT_W'(flag_q);
    endcase
  end

  if (CTRL_W > CNT_W) begin : g_width_check
    initial $error("reload_timer: CNT_W too narrow for control register");
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_addr,
  input logic             ovf_pulse,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preload,
  input logic             flag,
  input logic             en
);
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> cnt == $past(preload));

  p_flag_with_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> flag);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(reg_wr && reg_addr == 2'd3)) |=> flag);

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && !reg_wr) |=> $stable(cnt));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reg_wr) |=> $stable(cnt));
endmodule

bind reload_timer tmr_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .ovf_pulse(ovf_pulse), .cnt(cnt_q),
  .preload(preload_q), .flag(flag_q), .en(en_q)
);

// File: tb/test_reload_timer.sv
`timescale 1ns/1ps
module test_reload_timer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         ext_in = 1'b0;
  logic         ovf_pulse, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int ovf_seen = 0;

  always #10 clk = ~clk;

  reload_timer i_reload_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_in(ext_in), .ovf_pulse(ovf_pulse), .irq(irq)
  );

  always @(negedge clk) if (ovf_pulse) ovf_seen++;

  function automatic logic [W-1:0] ctl(bit en, int mode, bit pol, int psel, bit ie);
    return {ie, 3'(psel), pol, 2'(mode), en};
  endfunction

  function automatic int exp_val(int p, int n);
    return p + (n % (256 - p));
  endfunction

  function automatic int exp_ovf(int p, int n);
    return n / (256 - p);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] a, logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(logic [1:0] a, output int v);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v, v1, v2, p, s, k, n, ie;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    do_read(2'd2, v); chk("R1 counter", v, 0);
    do_read(2'd0, v); chk("R1 preload", v, 0);
    do_read(2'd1, v); chk("R1 control", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovf", ovf_pulse, 0);

    // R2 control readback of field layout
    do_write(2'd1, ctl(0, 2, 1, 5, 1));
    do_read(2'd1, v); chk("R2 control fields", v, 8'hDC);
    do_write(2'd1, 8'h00);

    // R3 R7 R10 random timer scenarios
    for (int i = 0; i < 10; i++) begin
      p  = (i == 0) ? 255 : int'($urandom_range(0, 254));
      s  = int'($urandom_range(0, 3));
      k  = int'($urandom_range(20, 400));
      ie = int'($urandom_range(0, 1));
      n  = k >> s;
      do_write(2'd0, 8'(p));
      ovf_seen = 0;
      do_write(2'd1, ctl(1, 0, 0, s, 1'(ie)));
      idle(k);
      do_read(2'd2, v);
      chk("R3 timer count", v, exp_val(p, n));
      #2 chk("R7 overflow pulses", ovf_seen, exp_ovf(p, n));
      do_read(2'd3, v);
      chk("R10 flag", v, exp_ovf(p, n) > 0 ? 1 : 0);
      chk("R10 irq", irq, (exp_ovf(p, n) > 0 && ie == 1) ? 1 : 0);
      do_write(2'd1, 8'h00);
      do_write(2'd3, 8'h00);
      do_read(2'd3, v);
      chk("R10 flag cleared", v, 0);
    end

    // R4 event mode, rising edges, prescaler select 7 ignored
    do_write(2'd0, 8'd10);
    do_write(2'd1, ctl(1, 1, 0, 7, 0));
    for (int j = 0; j < 5; j++) begin
      ext_in = 1'b1; idle(1); ext_in = 1'b1; idle(0);
      @(negedge clk); ext_in = 1'b0; repeat (2) @(negedge clk);
    end
    idle(4);
    do_read(2'd2, v); chk("R4 rising events", v, 15);
    do_write(2'd1, 8'h00);

    // R4 event mode, falling edges
    ext_in = 1'b1; idle(4);
    do_write(2'd0, 8'd40);
    do_write(2'd1, ctl(1, 1, 1, 0, 0));
    for (int j = 0; j < 7; j++) begin
      ext_in = 1'b0; repeat (2) @(negedge clk);
      ext_in = 1'b1; repeat (2) @(negedge clk);
    end
    idle(4);
    do_read(2'd2, v); chk("R4 falling events", v, 47);
    do_write(2'd1, 8'h00);

    // R5 R6 capture, count while low (ext_in currently high)
    do_write(2'd0, 8'd3);
    do_write(2'd1, ctl(1, 2, 1, 0, 0));
    idle(4);
    ext_in = 1'b0; repeat (9) @(negedge clk);
    ext_in = 1'b1; idle(5);
    do_read(2'd2, v); chk("R5 R6 capture low 9", v, 12);
    do_write(2'd1, 8'h00);

    // R5 R6 capture, count while high
    ext_in = 1'b0; idle(4);
    do_write(2'd0, 8'd100);
    do_write(2'd1, ctl(1, 2, 0, 0, 0));
    idle(3);
    ext_in = 1'b1; repeat (17) @(negedge clk);
    ext_in = 1'b0; idle(5);
    do_read(2'd2, v); chk("R5 R6 capture high 17", v, 117);
    do_write(2'd1, 8'h00);

    // R8 R9 inhibit and enable behaviour
    do_write(2'd0, 8'd0);
    do_write(2'd1, ctl(1, 0, 0, 0, 0));
    idle(10);
    do_read(2'd2, v1); chk("R9 start from preload", v1, 10);
    do_read(2'd2, v2); chk("R8 read inhibits", v2, v1);
    do_write(2'd0, 8'h50);
    do_read(2'd2, v); chk("R8 preload write inhibits", v, v1);
    idle(5);
    do_read(2'd2, v); chk("R8 resumes", v, v1 + 5);
    do_write(2'd1, 8'h00);
    do_read(2'd2, v1);
    idle(12);
    do_read(2'd2, v2); chk("R9 disabled holds", v2, v1);
    do_write(2'd1, ctl(1, 0, 0, 0, 0));
    do_read(2'd2, v); chk("R9 restart loads preload", v, 8'h50);
    do_write(2'd1, 8'h00);

    summary();
  end
endmodule